// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard logic of a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and writeback. It is purely combinational. From each pipeline register it takes the register specifiers, the write enables and the load flags. From these it produces bypass selects for the two operands entering execute, and a second set of bypass selects for the two operands of a branch. Branches are compared in decode, so those operands need their own forwarding.

It also produces one hold/bubble decision. A load in execute whose destination is read by the instruction in decode freezes the PC and the fetch/decode register for a cycle and zeroes the control entering execute. Because a branch compares in decode, it must also wait for a producer still in execute. When that producer is a load, the branch waits a further cycle while the load is in memory. The register file, the ALU, the operand muxes and the pipeline registers sit outside this block.

Top module: `hz_unit`

## Requirements
- R1: An execute operand whose specifier equals a nonzero memory-stage destination with its write enable high gets select code 2'b01 (memory-stage result).
- R2: Failing R1, an execute operand whose specifier equals a nonzero writeback-stage destination with its write enable high gets select code 2'b10 (writeback result).
- R3: Otherwise an execute operand gets select code 2'b00 (register file). Register 0 is never a bypass source, and code 2'b11 never appears.
- R4: Each decode (branch) operand is selected with the same codes and the same priority of memory over writeback over register file.
- R5: A load in execute (write enable and load flag high, destination nonzero) whose destination equals a decode source that is in use asserts the stall.
- R6: A branch in decode with an in-use source equal to a nonzero execute-stage destination with its write enable high asserts the stall, whether or not that producer is a load.
- R7: A branch in decode with an in-use source equal to a nonzero memory-stage destination of a load asserts the stall. A non-load producer in memory causes no stall.
- R8: A decode source whose use flag is low never causes a stall.
- R9: pc_hold, ifid_hold and idex_bubble are always equal, and they are high exactly when one of the conditions of R5, R6 or R7 holds.
- R10: A producer with destination register 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src | input | NSRC x AW | Source specifiers of the instruction in decode |
| id_use | input | NSRC | Per-source flag: the decode instruction actually reads this source |
| id_branch | input | 1 | The decode instruction is a compare-in-decode branch |
| ex_src | input | NSRC x AW | Source specifiers of the instruction in execute |
| ex_dst | input | AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Destination of the instruction in memory |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | AW | Destination of the instruction in writeback |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| ex_sel | output | NSRC x 2 | Execute operand bypass selects |
| id_sel | output | NSRC x 2 | Decode branch operand bypass selects |
| pc_hold | output | 1 | Keep the PC this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register this cycle |
| idex_bubble | output | 1 | Zero the control bits entering execute |

## Verification
The bench builds the unit with AW=3 and NSRC=2. With eight registers, random specifiers collide with each other and with register 0 often. Simultaneous memory and writeback matches, register-0 producers and load-versus-branch overlaps therefore all turn up many times across a few thousand vectors. Directed vectors walk a load-then-branch pair through its two stall cycles and cover the unused-source cases.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int SELW = 2;

    typedef enum logic [SELW-1:0] {
        SRC_RF  = 2'b00,
        SRC_MEM = 2'b01,
        SRC_WB  = 2'b10
    } src_sel_e;

    typedef struct packed {
        logic ld_use;
        logic br_ex;
        logic br_memld;
    } stall_why_t;

    function automatic src_sel_e pick_src(input logic mem_hit, input logic wb_hit);
        if (mem_hit)     return SRC_MEM;
        else if (wb_hit) return SRC_WB;
        else             return SRC_RF;
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          wen,
    output logic          hit
);
    always_comb hit = wen && (dst != '0) && (src == dst);
endmodule

// File: rtl/hz_src_pick.sv
module hz_src_pick
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]   src,
    input  logic [AW-1:0]   mem_dst,
    input  logic            mem_wen,
    input  logic [AW-1:0]   wb_dst,
    input  logic            wb_wen,
    output logic [SELW-1:0] sel
);
    logic mem_hit, wb_hit;

    hz_match #(.AW(AW)) u_mem (.src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit));
    hz_match #(.AW(AW)) u_wb  (.src(src), .dst(wb_dst),  .wen(wb_wen),  .hit(wb_hit));

    always_comb sel = pick_src(mem_hit, wb_hit);
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
    import hz_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [NSRC-1:0]         id_use,
    input  logic                    id_branch,
    input  logic [AW-1:0]           ex_dst,
    input  logic                    ex_wen,
    input  logic                    ex_load,
    input  logic [AW-1:0]           mem_dst,
    input  logic                    mem_wen,
    input  logic                    mem_load,
    output logic                    stall
);
    logic [NSRC-1:0] ex_hit, memld_hit;
    logic            memld_wen;
    stall_why_t      why;

    always_comb memld_wen = mem_wen && mem_load;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic ex_raw, mem_raw;
        hz_match #(.AW(AW)) u_ex  (.src(id_src[i]), .dst(ex_dst),  .wen(ex_wen),    .hit(ex_raw));
        hz_match #(.AW(AW)) u_mem (.src(id_src[i]), .dst(mem_dst), .wen(memld_wen), .hit(mem_raw));
        always_comb begin
            ex_hit[i]    = ex_raw  && id_use[i];
            memld_hit[i] = mem_raw && id_use[i];
        end
    end

    always_comb begin
        why.ld_use   = ex_load && (|ex_hit);
        why.br_ex    = id_branch && (|ex_hit);
        why.br_memld = id_branch && (|memld_hit);
        stall        = |why;
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0]   id_src,
    input  logic [NSRC-1:0]           id_use,
    input  logic                      id_branch,
    input  logic [NSRC-1:0][AW-1:0]   ex_src,
    input  logic [AW-1:0]             ex_dst,
    input  logic                      ex_wen,
    input  logic                      ex_load,
    input  logic [AW-1:0]             mem_dst,
    input  logic                      mem_wen,
    input  logic                      mem_load,
    input  logic [AW-1:0]             wb_dst,
    input  logic                      wb_wen,
    output logic [NSRC-1:0][SELW-1:0] ex_sel,
    output logic [NSRC-1:0][SELW-1:0] id_sel,
    output logic                      pc_hold,
    output logic                      ifid_hold,
    output logic                      idex_bubble
);
    logic stall;

    for (genvar i = 0; i < NSRC; i++) begin : g_op
        hz_src_pick #(.AW(AW)) u_ex_pick (
            .src(ex_src[i]), .mem_dst(mem_dst), .mem_wen(mem_wen),
            .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(ex_sel[i])
        );
        hz_src_pick #(.AW(AW)) u_id_pick (
            .src(id_src[i]), .mem_dst(mem_dst), .mem_wen(mem_wen),
            .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(id_sel[i])
        );
    end

    hz_stall_ctl #(.AW(AW), .NSRC(NSRC)) u_stall (
        .id_src(id_src), .id_use(id_use), .id_branch(id_branch),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .stall(stall)
    );

    always_comb begin
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input logic [NSRC-1:0][AW-1:0] id_src,
    input logic [NSRC-1:0]         id_use,
    input logic                    id_branch,
    input logic [NSRC-1:0][AW-1:0] ex_src,
    input logic [AW-1:0]           ex_dst,
    input logic                    ex_wen,
    input logic                    ex_load,
    input logic [AW-1:0]           mem_dst,
    input logic                    mem_wen,
    input logic                    mem_load,
    input logic [AW-1:0]           wb_dst,
    input logic                    wb_wen,
    input logic [NSRC-1:0][1:0]    ex_sel,
    input logic [NSRC-1:0][1:0]    id_sel,
    input logic                    pc_hold,
    input logic                    ifid_hold,
    input logic                    idex_bubble
);
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            // R1
            ex_mem_prio_chk: assert (!(mem_wen && mem_dst != '0 && ex_src[i] == mem_dst) || ex_sel[i] == 2'b01);
            // R3
            ex_code_legal_chk: assert (ex_sel[i] != 2'b11 && (ex_sel[i] == 2'b00 || ex_src[i] != '0));
            // R4
            id_code_legal_chk: assert (id_sel[i] != 2'b11 && (id_sel[i] == 2'b00 || id_src[i] != '0));
        end
        // R9
        hold_agree_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        // R8
        stall_needs_use_chk: assert (!pc_hold || (|id_use));
        // R10
        stall_needs_nonzero_chk: assert (!pc_hold || ex_dst != '0 || mem_dst != '0);
    end
endmodule

bind hz_unit hz_unit_chk #(.AW(AW), .NSRC(NSRC)) u_chk (
    .id_src(id_src), .id_use(id_use), .id_branch(id_branch),
    .ex_src(ex_src), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .ex_sel(ex_sel), .id_sel(id_sel),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
);

// File: tb/test_hz_unit.sv
module test_hz_unit;
    localparam int AW   = 3;
    localparam int NSRC = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [NSRC-1:0][AW-1:0] id_src, ex_src;
    logic [NSRC-1:0]         id_use;
    logic                    id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [AW-1:0]           ex_dst, mem_dst, wb_dst;
    logic [NSRC-1:0][1:0]    ex_sel, id_sel;
    logic                    pc_hold, ifid_hold, idex_bubble;

    int nvec = 0, nbad = 0;
    bit done = 0;

    hz_unit #(.AW(AW), .NSRC(NSRC)) i_hz_unit (
        .id_src(id_src), .id_use(id_use), .id_branch(id_branch),
        .ex_src(ex_src), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wen(wb_wen),
        .ex_sel(ex_sel), .id_sel(id_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    function automatic logic [1:0] ref_sel(input logic [AW-1:0] r);
        if (r == 0) return 2'b00;
        if (mem_wen && r == mem_dst) return 2'b01;
        if (wb_wen && r == wb_dst) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [1:0] e);
        return (e == 2'b01) ? "R1" : (e == 2'b10) ? "R2" : "R3";
    endfunction

    // returns 0 none, 5 load-use, 6 branch vs execute, 7 branch vs memory load
    function automatic int ref_cause();
        for (int i = 0; i < NSRC; i++)
            if (id_use[i] && id_src[i] != 0 && ex_wen && ex_load && id_src[i] == ex_dst) return 5;
        for (int i = 0; i < NSRC; i++)
            if (id_branch && id_use[i] && id_src[i] != 0 && ex_wen && id_src[i] == ex_dst) return 6;
        for (int i = 0; i < NSRC; i++)
            if (id_branch && id_use[i] && id_src[i] != 0 && mem_wen && mem_load && id_src[i] == mem_dst) return 7;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string stall_tag);
        int c;
        @(negedge clk);
        #1;
        for (int i = 0; i < NSRC; i++) begin
            check(sel_tag(ref_sel(ex_src[i])), ex_sel[i], ref_sel(ex_src[i]));
            check("R4", id_sel[i], ref_sel(id_src[i]));
        end
        c = ref_cause();
        check(stall_tag != "" ? stall_tag : (c == 5 ? "R5" : c == 6 ? "R6" : c == 7 ? "R7" : "R8"),
              {1'b0, pc_hold}, {1'b0, c != 0});
        check("R9", {1'b0, ifid_hold}, {1'b0, c != 0});
        check("R9", {1'b0, idex_bubble}, {1'b0, c != 0});
    endtask

    task automatic clear();
        id_src = '0; ex_src = '0; id_use = '0; id_branch = 0;
        ex_dst = '0; ex_wen = 0; ex_load = 0;
        mem_dst = '0; mem_wen = 0; mem_load = 0;
        wb_dst = '0; wb_wen = 0;
    endtask

    initial begin
        #800000;
        nbad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1997));
        clear();
        check_all("R9");                          // idle state: all RF, no hold

        // R1 over R2: both later stages write register 3
        clear(); ex_src[0] = 3; mem_dst = 3; mem_wen = 1; wb_dst = 3; wb_wen = 1;
        ex_src[1] = 5; wb_dst = 3;
        check_all("");
        // R2 and R3: register 0 producer ignored
        clear(); ex_src[0] = 0; mem_wen = 1; mem_dst = 0; ex_src[1] = 4; wb_wen = 1; wb_dst = 4;
        check_all("R10");
        // R5 load-use on the second source
        clear(); ex_wen = 1; ex_load = 1; ex_dst = 6; id_src[1] = 6; id_use = 2'b10;
        check_all("R5");
        // R8 same, but source unused
        id_use = 2'b01;
        check_all("R8");
        // R6 branch vs ALU producer in execute
        clear(); id_branch = 1; id_use = 2'b11; id_src[0] = 2; ex_wen = 1; ex_dst = 2;
        check_all("R6");
        // R6 then R7: load then branch, two stall cycles, then forward from WB
        clear(); id_branch = 1; id_use = 2'b11; id_src[0] = 1; ex_wen = 1; ex_load = 1; ex_dst = 1;
        check_all("R6");
        clear(); id_branch = 1; id_use = 2'b11; id_src[0] = 1; mem_wen = 1; mem_load = 1; mem_dst = 1;
        check_all("R7");
        clear(); id_branch = 1; id_use = 2'b11; id_src[0] = 1; wb_wen = 1; wb_dst = 1;
        check_all("R4");
        // R7: non-load in memory gives no stall, forwards instead
        clear(); id_branch = 1; id_use = 2'b11; id_src[1] = 7; mem_wen = 1; mem_dst = 7;
        check_all("R7");
        // R10 load to r0 with consumer of r0
        clear(); ex_wen = 1; ex_load = 1; ex_dst = 0; id_branch = 1; id_use = 2'b11;
        check_all("R10");

        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NSRC; i++) begin
                id_src[i] = AW'($urandom_range(0, 7));
                ex_src[i] = AW'($urandom_range(0, 7));
            end
            id_use    = NSRC'($urandom);
            id_branch = 1'($urandom);
            ex_dst    = AW'($urandom);  ex_wen  = 1'($urandom); ex_load  = ex_wen & 1'($urandom);
            mem_dst   = AW'($urandom);  mem_wen = 1'($urandom); mem_load = mem_wen & 1'($urandom);
            wb_dst    = AW'($urandom);  wb_wen  = 1'($urandom);
            check_all("");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule